// File: doc/BRIEF.md
# Shared-Bus Store-and-Forward Packet Switch

This block is a four-port packet switch that has no crossbar. All traffic moves over one internal bus, one transfer per clock. A round begins when any ingress stream offers a frame. In the first phase the switch visits the ingress ports one after another and copies each offered frame into a buffer that belongs to that port. Next comes a single lookup cycle. In that cycle every stored frame's destination tag is translated into an egress port through a small programmable table. In the last phase the buffers are drained one after another onto the egress streams.

A frame here is a single beat: a data word plus a destination tag. Each ingress and egress side is a valid/ready stream. The forwarding table has one entry per tag, and a write strobe updates one entry at a time. With one buffer per input and a free mapping from tags to outputs, a single round can deliver any permutation of the inputs to the outputs. A busy flag covers the whole round.

Top module: `sbsw_switch`

## Requirements
- R1: After reset `busy`, every `in_ready` and every `out_valid` are low, and table entry t holds egress port t (identity routing).
- R2: In the first cycle after `busy` rises, `in_ready[0]` is high. In each of the next cycles the next port (1, 2, 3) gets `in_ready`, and at most one `in_ready` is high in any cycle. A port's frame is taken only when its `in_valid` is high in its own slot.
- R3: A port whose `in_valid` is low in its gather slot has an empty buffer for that round, and nothing is sent on its behalf.
- R4: Writing with `cfg_we` high stores `cfg_port` at entry `cfg_tag` from the next cycle on. The lookup cycle right after gather maps each buffered frame to the egress port held at entry `in_tag` of that frame.
- R5: Scatter starts the cycle after lookup and visits buffers 0 to 3 in order. At most one `out_valid` is high per cycle, and `out_data` of that port carries the buffered word, while `out_data` of every other port is zero.
- R6: While `out_valid[p]` is high and `out_ready[p]` is low, the next cycle keeps `out_valid[p]` high with the same `out_data[p]`, and scatter does not advance.
- R7: Frames from several buffers that share an egress port leave that port in ascending buffer order.
- R8: `busy` stays high from the first gather cycle until the cycle after the last scatter slot completes. No `in_ready` is raised outside a port's gather slot, so a frame offered while a round is running waits for the next round.
- R9: With the table set to the reversal (tag t maps to port 3−t) and input i tagged i, one round delivers the frame of input i on egress port 3−i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-ingress frame offered |
| in_ready | output | 4 | Per-ingress frame taken this cycle when valid |
| in_data | input | 4x16 | Per-ingress data word |
| in_tag | input | 4x2 | Per-ingress destination tag |
| out_valid | output | 4 | Per-egress frame present |
| out_ready | input | 4 | Per-egress sink accepts |
| out_data | output | 4x16 | Per-egress data word |
| cfg_we | input | 1 | Forwarding table write strobe |
| cfg_tag | input | 2 | Table entry to write |
| cfg_port | input | 2 | Egress port stored in the entry |
| busy | output | 1 | A round is in progress |

## Verification
Some properties are checked on every cycle: a single ingress grant, a single egress transfer, stall hold on each egress, the gather pointer stepping through the ports, an unfilled slot leaving its buffer empty, table writes landing in the next cycle, and no grant while idle. These hold for any traffic. Other behaviour only the bench scenarios can show, by comparing against a behavioural model and against per-port received lists. That covers end-to-end routing through a reprogrammed table, a full reversal permutation, skipped inputs, several frames funnelled into one stalled output in buffer order, and a second frame that has to wait for the next round.

// File: rtl/sbsw_pkg.sv
package sbsw_pkg;

    // Round phases of the shared-bus sequencer
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_GATHER  = 2'd1,
        PH_LOOKUP  = 2'd2,
        PH_SCATTER = 2'd3
    } phase_e;

endpackage

// File: rtl/sbsw_fwd_table.sv
module sbsw_fwd_table #(
    parameter int NPORTS = 4,
    parameter int NTAGS  = 4,
    localparam int PW    = $clog2(NPORTS),
    localparam int TW    = $clog2(NTAGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [TW-1:0]                cfg_tag,
    input  logic [PW-1:0]                cfg_port,
    output logic [NTAGS-1:0][PW-1:0]     ent
);

    typedef struct packed {
        logic [NTAGS-1:0][PW-1:0] ent;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (cfg_we) begin
            t_d.ent[cfg_tag] = cfg_port;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAGS; i++) begin
                t_q.ent[i] <= PW'(i % NPORTS);
            end
        end else begin
            t_q <= t_d;
        end
    end

    assign ent = t_q.ent;

    // R4
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (t_q.ent[$past(cfg_tag)] == $past(cfg_port)));

endmodule

// File: rtl/sbsw_seq_ctrl.sv
module sbsw_seq_ctrl
    import sbsw_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int PW    = $clog2(NPORTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          slot_done,
    output phase_e        phase,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(NPORTS - 1);

    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] ptr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_GATHER;
                    s_d.ptr = '0;
                end
            end
            PH_GATHER: begin
                if (s_q.ptr == LAST) begin
                    s_d.ph  = PH_LOOKUP;
                    s_d.ptr = '0;
                end else begin
                    s_d.ptr = s_q.ptr + PW'(1);
                end
            end
            PH_LOOKUP: begin
                s_d.ph  = PH_SCATTER;
                s_d.ptr = '0;
            end
            PH_SCATTER: begin
                if (slot_done) begin
                    if (s_q.ptr == LAST) begin
                        s_d.ph  = PH_IDLE;
                        s_d.ptr = '0;
                    end else begin
                        s_d.ptr = s_q.ptr + PW'(1);
                    end
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.ptr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.ptr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign ptr   = s_q.ptr;

    // R2
    gather_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GATHER && s_q.ptr != LAST)
        |=> (s_q.ph == PH_GATHER && s_q.ptr == $past(s_q.ptr) + PW'(1)));

endmodule

// File: rtl/sbsw_frame_buf.sv
module sbsw_frame_buf
    import sbsw_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NTAGS  = 4,
    parameter int DW     = 16,
    localparam int PW    = $clog2(NPORTS),
    localparam int TW    = $clog2(NTAGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  phase_e                        phase,
    input  logic [PW-1:0]                 ptr,
    input  logic [NPORTS-1:0]             in_valid,
    input  logic [NPORTS-1:0][DW-1:0]     in_data,
    input  logic [NPORTS-1:0][TW-1:0]     in_tag,
    input  logic [NTAGS-1:0][PW-1:0]      tbl,
    input  logic                          sent,
    output logic [NPORTS-1:0]             full,
    output logic [NPORTS-1:0][DW-1:0]     data,
    output logic [NPORTS-1:0][PW-1:0]     dst
);

    typedef struct packed {
        logic [NPORTS-1:0]         full;
        logic [NPORTS-1:0][DW-1:0] data;
        logic [NPORTS-1:0][TW-1:0] tag;
        logic [NPORTS-1:0][PW-1:0] dst;
    } bufs_t;

    bufs_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        unique case (phase)
            PH_GATHER: begin
                b_d.full[ptr] = in_valid[ptr];
                if (in_valid[ptr]) begin
                    b_d.data[ptr] = in_data[ptr];
                    b_d.tag[ptr]  = in_tag[ptr];
                end
            end
            PH_LOOKUP: begin
                for (int i = 0; i < NPORTS; i++) begin
                    b_d.dst[i] = tbl[b_q.tag[i]];
                end
            end
            PH_SCATTER: begin
                if (sent) begin
                    b_d.full[ptr] = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign full = b_q.full;
    assign data = b_q.data;
    assign dst  = b_q.dst;

    // R3
    skip_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_GATHER && !in_valid[ptr]) |=> !b_q.full[$past(ptr)]);

endmodule

// File: rtl/sbsw_switch.sv
module sbsw_switch
    import sbsw_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NTAGS  = 4,
    parameter int DW     = 16,
    localparam int PW    = $clog2(NPORTS),
    localparam int TW    = $clog2(NTAGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORTS-1:0]             in_valid,
    output logic [NPORTS-1:0]             in_ready,
    input  logic [NPORTS-1:0][DW-1:0]     in_data,
    input  logic [NPORTS-1:0][TW-1:0]     in_tag,
    output logic [NPORTS-1:0]             out_valid,
    input  logic [NPORTS-1:0]             out_ready,
    output logic [NPORTS-1:0][DW-1:0]     out_data,
    input  logic                          cfg_we,
    input  logic [TW-1:0]                 cfg_tag,
    input  logic [PW-1:0]                 cfg_port,
    output logic                          busy
);

    phase_e                     phase;
    logic [PW-1:0]              ptr;
    logic [NTAGS-1:0][PW-1:0]   tbl;
    logic [NPORTS-1:0]          buf_full;
    logic [NPORTS-1:0][DW-1:0]  buf_data;
    logic [NPORTS-1:0][PW-1:0]  buf_dst;
    logic                       cur_full;
    logic [PW-1:0]              cur_dst;
    logic [DW-1:0]              bus_word;
    logic                       slot_done;
    logic                       sent;

    sbsw_fwd_table #(.NPORTS(NPORTS), .NTAGS(NTAGS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_tag  (cfg_tag),
        .cfg_port (cfg_port),
        .ent      (tbl)
    );

    sbsw_seq_ctrl #(.NPORTS(NPORTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (|in_valid),
        .slot_done (slot_done),
        .phase     (phase),
        .ptr       (ptr)
    );

    sbsw_frame_buf #(.NPORTS(NPORTS), .NTAGS(NTAGS), .DW(DW)) u_bufs (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .ptr      (ptr),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_tag   (in_tag),
        .tbl      (tbl),
        .sent     (sent),
        .full     (buf_full),
        .data     (buf_data),
        .dst      (buf_dst)
    );

    // Shared bus: the buffer under the pointer is the only source
    always_comb begin
        cur_full  = buf_full[ptr];
        cur_dst   = buf_dst[ptr];
        bus_word  = buf_data[ptr];
        slot_done = !cur_full || out_ready[cur_dst];
        sent      = (phase == PH_SCATTER) && cur_full && out_ready[cur_dst];
        busy      = (phase != PH_IDLE);
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_comb begin
            in_ready[p]  = (phase == PH_GATHER) && (ptr == PW'(p));
            out_valid[p] = (phase == PH_SCATTER) && cur_full && (cur_dst == PW'(p));
            out_data[p]  = out_valid[p] ? bus_word : '0;
        end

        // R6
        egress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_data[p])));
    end

    // R2
    ingress_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R5
    bus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R8
    idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (in_ready == '0 && out_valid == '0));

endmodule

// File: tb/sbsw_switch_tb.sv
`timescale 1ns/1ps
module sbsw_switch_tb;
    localparam int N  = 4;
    localparam int NT = 4;
    localparam int DW = 16;
    localparam int PW = 2;
    localparam int TW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst_n;
    logic [N-1:0]          in_valid, in_ready, out_valid, out_ready;
    logic [N-1:0][DW-1:0]  in_data, out_data;
    logic [N-1:0][TW-1:0]  in_tag;
    logic                  cfg_we;
    logic [TW-1:0]         cfg_tag;
    logic [PW-1:0]         cfg_port;
    logic                  busy;

    sbsw_switch u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cfg_we(cfg_we), .cfg_tag(cfg_tag), .cfg_port(cfg_port), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int rdy_mode = 0;

    // behavioural reference model
    int            m_ph  = 0;
    int            m_ptr = 0;
    bit            m_full [N];
    logic [DW-1:0] m_data [N];
    int            m_tag  [N];
    int            m_dst  [N];
    int            m_tbl  [NT];

    logic [DW-1:0] src_d [N][$];
    int            src_t [N][$];
    logic [DW-1:0] got   [N][$];

    task automatic chk(string r, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic bit srcs_empty();
        for (int p = 0; p < N; p++) if (src_d[p].size() != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic step();
        logic [N-1:0]         e_rdy, e_ov;
        logic [N-1:0][DW-1:0] e_dat;
        int nph, nptr;
        bit adv;
        @(negedge clk);
        for (int p = 0; p < N; p++) begin
            in_valid[p]  = (src_d[p].size() != 0);
            in_data[p]   = in_valid[p] ? src_d[p][0] : '0;
            in_tag[p]    = in_valid[p] ? TW'(src_t[p][0]) : '0;
            out_ready[p] = (rdy_mode == 0) ? 1'b1 : (((cyc + p) % 3) != 0);
        end
        #1;
        e_rdy = '0; e_ov = '0; e_dat = '0;
        for (int p = 0; p < N; p++) begin
            e_rdy[p] = (m_ph == 1) && (m_ptr == p);
            if (m_ph == 3 && m_full[m_ptr] && m_dst[m_ptr] == p) begin
                e_ov[p]  = 1'b1;
                e_dat[p] = m_data[m_ptr];
            end
        end
        chk("R8", 64'(busy), 64'(m_ph != 0), "busy");
        chk("R2", 64'(in_ready), 64'(e_rdy), "in_ready");
        chk("R5", 64'(out_valid), 64'(e_ov), "out_valid");
        chk("R5", 64'(out_data), 64'(e_dat), "out_data");
        @(posedge clk);
        nph = m_ph; nptr = m_ptr; adv = 1'b0;
        if (!rst_n) begin
            nph = 0; nptr = 0;
            for (int i = 0; i < N; i++) m_full[i] = 1'b0;
        end else begin
            case (m_ph)
                0: if (in_valid != '0) begin nph = 1; nptr = 0; end
                1: begin
                    if (in_valid[m_ptr]) begin
                        m_full[m_ptr] = 1'b1;
                        m_data[m_ptr] = src_d[m_ptr].pop_front();
                        m_tag[m_ptr]  = src_t[m_ptr].pop_front();
                    end else begin
                        m_full[m_ptr] = 1'b0;
                    end
                    if (m_ptr == N-1) begin nph = 2; nptr = 0; end
                    else nptr = m_ptr + 1;
                end
                2: begin
                    for (int i = 0; i < N; i++) m_dst[i] = m_tbl[m_tag[i]];
                    nph = 3; nptr = 0;
                end
                default: begin
                    if (!m_full[m_ptr]) adv = 1'b1;
                    else if (out_ready[m_dst[m_ptr]]) begin
                        got[m_dst[m_ptr]].push_back(m_data[m_ptr]);
                        m_full[m_ptr] = 1'b0;
                        adv = 1'b1;
                    end
                    if (adv) begin
                        if (m_ptr == N-1) begin nph = 0; nptr = 0; end
                        else nptr = m_ptr + 1;
                    end
                end
            endcase
            if (cfg_we) m_tbl[cfg_tag] = int'(cfg_port);
        end
        m_ph = nph; m_ptr = nptr;
        cyc++;
    endtask

    task automatic prog(int tag, int port);
        cfg_we = 1'b1; cfg_tag = TW'(tag); cfg_port = PW'(port);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic drain_round();
        int guard = 0;
        do begin
            step();
            guard++;
        end while (!(m_ph == 0 && srcs_empty()) && guard < 500);
        step();
    endtask

    // sends one frame on each input in mask, input i tagged tags[i], word base+i
    task automatic run_frames(logic [N-1:0] mask, input int tags[N], logic [DW-1:0] base, string req);
        logic [DW-1:0] exp [N][$];
        for (int p = 0; p < N; p++) begin
            got[p].delete();
            exp[p].delete();
        end
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                src_d[i].push_back(base + DW'(i));
                src_t[i].push_back(tags[i]);
                exp[m_tbl[tags[i]]].push_back(base + DW'(i));
            end
        end
        drain_round();
        for (int p = 0; p < N; p++) begin
            chk(req, 64'(got[p].size()), 64'(exp[p].size()), $sformatf("frame count on port %0d", p));
            for (int k = 0; k < exp[p].size() && k < got[p].size(); k++)
                chk(req, 64'(got[p][k]), 64'(exp[p][k]), $sformatf("word %0d on port %0d", k, p));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) m_tbl[t] = t % N;
        for (int i = 0; i < N; i++) begin m_full[i] = 0; m_data[i] = '0; m_tag[i] = 0; m_dst[i] = 0; end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_tag = '0; cfg_port = '0;
        in_valid = '0; in_data = '0; in_tag = '0; out_ready = '0;
        step(); step();
        // R1: reset state at the ports
        chk("R1", 64'(busy), 64'(0), "busy after reset");
        chk("R1", 64'(in_ready), 64'(0), "in_ready after reset");
        chk("R1", 64'(out_valid), 64'(0), "out_valid after reset");
        rst_n = 1'b1;
        step();

        // R1: identity routing from reset table
        run_frames(4'b1111, '{0, 1, 2, 3}, 16'h1000, "R1");
        // R9: reversal permutation
        prog(0, 3); prog(1, 2); prog(2, 1); prog(3, 0);
        run_frames(4'b1111, '{0, 1, 2, 3}, 16'h2000, "R9");
        // R3: idle inputs are skipped
        run_frames(4'b1010, '{0, 1, 2, 3}, 16'h3000, "R3");
        run_frames(4'b0001, '{0, 0, 0, 2}, 16'h3100, "R3");
        // R4: reprogrammed table, mixed tags
        prog(0, 1); prog(1, 3); prog(2, 0); prog(3, 2);
        run_frames(4'b1111, '{2, 0, 3, 1}, 16'h4000, "R4");
        // R6 / R7: all to one stalled port, buffer order kept
        prog(0, 2); prog(1, 2); prog(2, 2); prog(3, 2);
        rdy_mode = 1;
        run_frames(4'b1111, '{0, 1, 2, 3}, 16'h5000, "R7");
        run_frames(4'b1101, '{3, 0, 1, 2}, 16'h5100, "R6");
        rdy_mode = 0;
        // R8: second frame on a port waits for the next round
        prog(0, 0); prog(1, 1); prog(2, 2); prog(3, 3);
        for (int p = 0; p < N; p++) got[p].delete();
        src_d[0].push_back(16'h6001); src_t[0].push_back(1);
        src_d[0].push_back(16'h6002); src_t[0].push_back(3);
        src_d[2].push_back(16'h6003); src_t[2].push_back(1);
        drain_round();
        chk("R8", 64'(got[1].size()), 64'(2), "frames on port 1");
        if (got[1].size() == 2) begin
            chk("R8", 64'(got[1][0]), 64'(16'h6001), "first on port 1");
            chk("R8", 64'(got[1][1]), 64'(16'h6003), "second on port 1");
        end
        chk("R8", 64'(got[3].size()), 64'(1), "late frame on port 3");
        if (got[3].size() == 1) chk("R8", 64'(got[3][0]), 64'(16'h6002), "late word on port 3");

        step(); step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule